// File: doc/BRIEF.md
# CPU Exception Entry and Return Unit

This unit takes exceptions into their handlers and brings the processor back out of them, for a 32-bit core whose branches have a delay slot. When the pipeline raises an exception, it gives an exception code, the PC of the instruction that faulted and a flag that says whether that instruction sat in a delay slot. On the next clock edge the unit does four things. It stores a resume PC, which depends on the exception class and on the delay-slot flag. It keeps a copy of the status register. It writes the delay-slot flag into the status register. It issues a one-cycle redirect to the handler vector. A trap code does not vector: it raises a one-cycle halt request that carries the PC. An unknown code raises a one-cycle error flag and changes no state.

A return request copies the saved status back into the status register, sets the fixed-one bit and redirects fetch to the saved PC. Every redirect also pulses a cancel for any pending delay slot. The pipeline loads the status register through a write port, which serves for mode and prefix changes. That write is dropped in any cycle that has an entry or a return.

Top module: `cpu_exc_ctrl`

## Requirements
- R1: After synchronous reset, `sr` is 0x0000_8000 (only bit 15, the fixed-one bit, is set). `esr`, `epc` and `eear` are 0, and `redirect_valid`, `halt_valid`, `bad_code` and `cancel_dslot` are 0.
- R2: Entry with code 0xC (system call) or 0xD (floating point) sets `epc` to `fault_pc + 4`. When `in_dslot` is 1 it sets `epc` to `fault_pc`.
- R3: Entry with code 0x2 (bus error), 0x6 (alignment), 0x7 (illegal instruction) or 0xB (range) sets `epc` to `fault_pc`. When `in_dslot` is 1 it sets `epc` to `fault_pc - 4`.
- R4: Entry with code 0x1 (reset) leaves `epc` unchanged but otherwise enters like any other vectoring exception.
- R5: A vectoring entry copies the old `sr` into `esr`. The new `sr` is the old one with bit 13 replaced by `in_dslot`.
- R6: One cycle after a vectoring entry, `redirect_valid` is 1 for one cycle and `redirect_pc` is `code << 8`. When `sr` bit 14 was 1 at entry, 0xF000_0000 is added to that value.
- R7: Entry with code 0xE (trap) gives `halt_valid` = 1 for one cycle with `halt_pc` = `fault_pc`. It causes no redirect and leaves `sr`, `esr`, `epc` and `eear` unchanged.
- R8: Entry with code 0x7 loads `eear` with `fault_pc`. No other code changes `eear`.
- R9: A return with no entry in the same cycle sets `sr` to `esr` with bit 15 forced to 1. One cycle later it redirects to the `epc` value held when the return was requested.
- R10: `cancel_dslot` pulses for one cycle together with every vectoring entry and every return, and at no other time.
- R11: Entry with any other code (0x0, 0x3–0x5, 0x8–0xA, 0xF) gives `bad_code` = 1 for one cycle. It causes no redirect and no halt, and changes no state.
- R12: When entry and return are requested in the same cycle, only the entry takes effect.
- R13: `sr_wr_en` loads `sr` from `sr_wr_data` only in a cycle with neither `entry_req` nor `ret_req`; otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Exception entry request |
| exc_code | input | 4 | Exception code |
| fault_pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| ret_req | input | 1 | Return-from-exception request |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | 32 | Status register write value |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| halt_valid | output | 1 | Debug halt pulse (trap) |
| halt_pc | output | 32 | PC carried with the halt |
| bad_code | output | 1 | Unsupported exception code pulse |
| cancel_dslot | output | 1 | Cancel pending delay slot |
| sr | output | 32 | Status register |
| esr | output | 32 | Saved status register |
| epc | output | 32 | Saved exception PC |
| eear | output | 32 | Effective-address register |

## Verification
The bench runs each class with the delay-slot flag clear and then set. A design that swapped the two PC adjustments, or ignored the flag, would resume one instruction early or late. Reset-code entries are given a different PC from the one held in `epc`, so an update that should not happen shows up. Vectors are checked with the prefix bit both clear and set, which exposes a wrong base or a shift sampled after the status update. Traps, unknown codes and writes to the status register that collide with an entry or a return are each followed by a full state comparison. Any leak would show up as a changed `sr`, `esr`, `epc` or `eear`, or as a stray redirect.

// File: rtl/cpu_exc_pkg.sv
package cpu_exc_pkg;

    parameter int XLEN       = 32;
    parameter int CODE_W     = 4;
    parameter int INSN_BYTES = 4;
    parameter int VEC_SHIFT  = 8;
    parameter logic [XLEN-1:0] HI_BASE = 32'hF000_0000;

    parameter int SR_DSX_BIT = 13;
    parameter int SR_PFX_BIT = 14;
    parameter int SR_FO_BIT  = 15;

    localparam logic [XLEN-1:0] SR_FO_MASK  = XLEN'(1) << SR_FO_BIT;
    localparam logic [XLEN-1:0] SR_RST_VAL  = SR_FO_MASK;
    localparam logic [XLEN-1:0] INSN_STEP   = XLEN'(INSN_BYTES);

    typedef enum logic [CODE_W-1:0] {
        EXC_RESET = 4'h1,
        EXC_BUS   = 4'h2,
        EXC_ALIGN = 4'h6,
        EXC_ILL   = 4'h7,
        EXC_RANGE = 4'hB,
        EXC_SYSC  = 4'hC,
        EXC_FPE   = 4'hD,
        EXC_TRAP  = 4'hE
    } exc_code_e;

    typedef enum logic [1:0] {
        PCK_KEEP  = 2'd0,
        PCK_AT    = 2'd1,
        PCK_AFTER = 2'd2
    } pc_kind_e;

    typedef struct packed {
        logic     known;
        logic     trap;
        logic     ill;
        pc_kind_e kind;
    } exc_class_t;

    typedef struct packed {
        logic [XLEN-1:0] epc_next;
        logic [XLEN-1:0] vector;
        logic [XLEN-1:0] sr_entry;
        logic [XLEN-1:0] sr_return;
    } exc_target_t;

    function automatic exc_class_t classify(input logic [CODE_W-1:0] code);
        exc_class_t c;
        c = '{known: 1'b1, trap: 1'b0, ill: 1'b0, kind: PCK_KEEP};
        case (code)
            EXC_RESET: c.kind = PCK_KEEP;
            EXC_BUS, EXC_ALIGN, EXC_RANGE: c.kind = PCK_AT;
            EXC_ILL: begin
                c.kind = PCK_AT;
                c.ill  = 1'b1;
            end
            EXC_SYSC, EXC_FPE: c.kind = PCK_AFTER;
            EXC_TRAP: c.trap = 1'b1;
            default: c.known = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] resume_pc(
        input pc_kind_e        kind,
        input logic [XLEN-1:0] pc,
        input logic            dslot,
        input logic [XLEN-1:0] old_epc
    );
        logic [XLEN-1:0] back;
        back = dslot ? INSN_STEP : '0;
        case (kind)
            PCK_AT:    return pc - back;
            PCK_AFTER: return pc + INSN_STEP - back;
            default:   return old_epc;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] handler_addr(
        input logic [CODE_W-1:0] code,
        input logic              prefix
    );
        logic [XLEN-1:0] off;
        off = XLEN'(code) << VEC_SHIFT;
        return (prefix ? HI_BASE : '0) + off;
    endfunction

endpackage

// File: rtl/cpu_exc_decode.sv
module cpu_exc_decode
    import cpu_exc_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code,
    output exc_class_t    cls
);
    always_comb begin
        cls = classify(code);
    end
endmodule

// File: rtl/cpu_exc_target.sv
module cpu_exc_target
    import cpu_exc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  exc_class_t    cls,
    input  logic [CW-1:0] code,
    input  logic [W-1:0]  fault_pc,
    input  logic          in_dslot,
    input  logic [W-1:0]  sr_q,
    input  logic [W-1:0]  esr_q,
    input  logic [W-1:0]  epc_q,
    output exc_target_t   tgt
);
    logic [W-1:0] sr_dsx;

    always_comb begin
        sr_dsx             = sr_q;
        sr_dsx[SR_DSX_BIT] = in_dslot;
    end

    always_comb begin
        tgt.epc_next  = resume_pc(cls.kind, fault_pc, in_dslot, epc_q);
        tgt.vector    = handler_addr(code, sr_q[SR_PFX_BIT]);
        tgt.sr_entry  = sr_dsx;
        tgt.sr_return = esr_q | SR_FO_MASK;
    end
endmodule

// File: rtl/cpu_exc_state.sv
module cpu_exc_state
    import cpu_exc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        entry_req,
    input  logic        ret_req,
    input  logic        sr_wr_en,
    input  logic [W-1:0] sr_wr_data,
    input  logic [W-1:0] fault_pc,
    input  exc_class_t  cls,
    input  exc_target_t tgt,
    output logic        redirect_valid,
    output logic [W-1:0] redirect_pc,
    output logic        halt_valid,
    output logic [W-1:0] halt_pc,
    output logic        bad_code,
    output logic        cancel_dslot,
    output logic [W-1:0] sr_q,
    output logic [W-1:0] esr_q,
    output logic [W-1:0] epc_q,
    output logic [W-1:0] eear_q
);
    typedef enum logic [2:0] {
        ACT_IDLE, ACT_VECTOR, ACT_TRAP, ACT_BAD, ACT_RETURN, ACT_SRWR
    } act_e;

    act_e act;

    always_comb begin
        act = ACT_IDLE;
        if (entry_req) begin
            if (!cls.known)    act = ACT_BAD;
            else if (cls.trap) act = ACT_TRAP;
            else               act = ACT_VECTOR;
        end else if (ret_req) begin
            act = ACT_RETURN;
        end else if (sr_wr_en) begin
            act = ACT_SRWR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            halt_valid     <= 1'b0;
            halt_pc        <= '0;
            bad_code       <= 1'b0;
            cancel_dslot   <= 1'b0;
            sr_q           <= SR_RST_VAL;
            esr_q          <= '0;
            epc_q          <= '0;
            eear_q         <= '0;
        end else begin
            redirect_valid <= 1'b0;
            halt_valid     <= 1'b0;
            bad_code       <= 1'b0;
            cancel_dslot   <= 1'b0;
            case (act)
                ACT_VECTOR: begin
                    epc_q          <= tgt.epc_next;
                    esr_q          <= sr_q;
                    sr_q           <= tgt.sr_entry;
                    if (cls.ill) eear_q <= fault_pc;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= tgt.vector;
                    cancel_dslot   <= 1'b1;
                end
                ACT_TRAP: begin
                    halt_valid <= 1'b1;
                    halt_pc    <= fault_pc;
                end
                ACT_BAD: bad_code <= 1'b1;
                ACT_RETURN: begin
                    sr_q           <= tgt.sr_return;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= epc_q;
                    cancel_dslot   <= 1'b1;
                end
                ACT_SRWR: sr_q <= sr_wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpu_exc_ctrl.sv
module cpu_exc_ctrl
    import cpu_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              entry_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   fault_pc,
    input  logic              in_dslot,
    input  logic              ret_req,
    input  logic              sr_wr_en,
    input  logic [XLEN-1:0]   sr_wr_data,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              halt_valid,
    output logic [XLEN-1:0]   halt_pc,
    output logic              bad_code,
    output logic              cancel_dslot,
    output logic [XLEN-1:0]   sr,
    output logic [XLEN-1:0]   esr,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   eear
);
    exc_class_t  cls;
    exc_target_t tgt;

    cpu_exc_decode #(.CW(CODE_W)) u_decode (
        .code (exc_code),
        .cls  (cls)
    );

    cpu_exc_target #(.W(XLEN), .CW(CODE_W)) u_target (
        .cls      (cls),
        .code     (exc_code),
        .fault_pc (fault_pc),
        .in_dslot (in_dslot),
        .sr_q     (sr),
        .esr_q    (esr),
        .epc_q    (epc),
        .tgt      (tgt)
    );

    cpu_exc_state #(.W(XLEN)) u_state (
        .clk            (clk),
        .rst            (rst),
        .entry_req      (entry_req),
        .ret_req        (ret_req),
        .sr_wr_en       (sr_wr_en),
        .sr_wr_data     (sr_wr_data),
        .fault_pc       (fault_pc),
        .cls            (cls),
        .tgt            (tgt),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .halt_valid     (halt_valid),
        .halt_pc        (halt_pc),
        .bad_code       (bad_code),
        .cancel_dslot   (cancel_dslot),
        .sr_q           (sr),
        .esr_q          (esr),
        .epc_q          (epc),
        .eear_q         (eear)
    );
endmodule

// File: rtl/cpu_exc_ctrl_chk.sv
module cpu_exc_ctrl_chk
    import cpu_exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              entry_req,
    input logic [CODE_W-1:0] exc_code,
    input logic              ret_req,
    input logic              redirect_valid,
    input logic              halt_valid,
    input logic              bad_code,
    input logic              cancel_dslot,
    input logic [XLEN-1:0]   sr,
    input logic [XLEN-1:0]   esr,
    input logic [XLEN-1:0]   epc
);
    logic is_trap;
    logic is_vec;
    assign is_trap = (exc_code == 4'hE);
    assign is_vec  = (exc_code == 4'h1) || (exc_code == 4'h2) || (exc_code == 4'h6) ||
                     (exc_code == 4'h7) || (exc_code == 4'hB) || (exc_code == 4'hC) ||
                     (exc_code == 4'hD);

    p_trap_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        halt_valid |-> !redirect_valid);

    p_trap_keeps_state_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(entry_req && is_trap && !rst)) |-> ($stable(sr) && $stable(esr) && $stable(epc)));

    p_bad_is_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        bad_code |-> (!redirect_valid && !halt_valid && !cancel_dslot));

    p_cancel_with_redirect_r10: assert property (@(posedge clk) disable iff (rst)
        cancel_dslot |-> redirect_valid);

    p_fo_after_return_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_req && !entry_req && !rst)) |-> sr[SR_FO_BIT]);

    p_esr_saves_sr_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(entry_req && is_vec && !rst)) |-> (esr == $past(sr)));

    p_entry_wins_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(entry_req && ret_req && is_vec && !rst)) |-> (esr == $past(sr)));
endmodule

bind cpu_exc_ctrl cpu_exc_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .entry_req      (entry_req),
    .exc_code       (exc_code),
    .ret_req        (ret_req),
    .redirect_valid (redirect_valid),
    .halt_valid     (halt_valid),
    .bad_code       (bad_code),
    .cancel_dslot   (cancel_dslot),
    .sr             (sr),
    .esr            (esr),
    .epc            (epc)
);

// File: tb/cpu_exc_ctrl_tb_top.sv
module cpu_exc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        entry_req = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] fault_pc = '0;
    logic        in_dslot = 1'b0;
    logic        ret_req = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic        redirect_valid, halt_valid, bad_code, cancel_dslot;
    logic [31:0] redirect_pc, halt_pc, sr, esr, epc, eear;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_sr, m_esr, m_epc, m_eear, m_rpc, m_hpc;
    logic        m_rv, m_hv, m_bad, m_can;

    always #2.5 clk = ~clk;

    cpu_exc_ctrl dut_i (
        .clk(clk), .rst(rst), .entry_req(entry_req), .exc_code(exc_code),
        .fault_pc(fault_pc), .in_dslot(in_dslot), .ret_req(ret_req),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .halt_valid(halt_valid), .halt_pc(halt_pc), .bad_code(bad_code),
        .cancel_dslot(cancel_dslot), .sr(sr), .esr(esr), .epc(epc), .eear(eear)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "sr", sr, m_sr);
        chk(tag, "esr", esr, m_esr);
        chk(tag, "epc", epc, m_epc);
        chk(tag, "eear", eear, m_eear);
        chk(tag, "redirect_valid", 32'(redirect_valid), 32'(m_rv));
        if (m_rv) chk(tag, "redirect_pc", redirect_pc, m_rpc);
        chk(tag, "halt_valid", 32'(halt_valid), 32'(m_hv));
        if (m_hv) chk(tag, "halt_pc", halt_pc, m_hpc);
        chk(tag, "bad_code", 32'(bad_code), 32'(m_bad));
        chk(tag, "cancel_dslot", 32'(cancel_dslot), 32'(m_can));
    endtask

    // behavioural model of one clock edge
    task automatic model_edge(input logic en, input int code, input logic [31:0] pc,
                              input logic ds, input logic rt, input logic we,
                              input logic [31:0] wd);
        int kind; // 0 keep, 1 at, 2 after, -1 trap, -2 unknown
        m_rv = 0; m_hv = 0; m_bad = 0; m_can = 0;
        case (code)
            1: kind = 0;
            2, 6, 7, 11: kind = 1;
            12, 13: kind = 2;
            14: kind = -1;
            default: kind = -2;
        endcase
        if (en) begin
            if (kind == -2) m_bad = 1;
            else if (kind == -1) begin m_hv = 1; m_hpc = pc; end
            else begin
                m_rv  = 1; m_can = 1;
                m_rpc = (m_sr[14] ? 32'hF000_0000 : 32'h0) + 32'(code * 256);
                if (kind == 1) m_epc = ds ? pc - 4 : pc;
                if (kind == 2) m_epc = ds ? pc : pc + 4;
                if (code == 7) m_eear = pc;
                m_esr = m_sr;
                m_sr[13] = ds;
            end
        end else if (rt) begin
            m_sr = m_esr | 32'h0000_8000;
            m_rv = 1; m_can = 1; m_rpc = m_epc;
        end else if (we) begin
            m_sr = wd;
        end
    endtask

    task automatic op(input string tag, input logic en, input int code,
                      input logic [31:0] pc, input logic ds, input logic rt,
                      input logic we, input logic [31:0] wd);
        @(negedge clk);
        entry_req = en; exc_code = 4'(code); fault_pc = pc; in_dslot = ds;
        ret_req = rt; sr_wr_en = we; sr_wr_data = wd;
        @(posedge clk);
        model_edge(en, code, pc, ds, rt, we, wd);
        #1;
        compare_all(tag);
        @(negedge clk);
        entry_req = 0; ret_req = 0; sr_wr_en = 0;
        @(posedge clk);
        model_edge(0, 0, 0, 0, 0, 0, 0);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_sr = 32'h0000_8000; m_esr = 0; m_epc = 0; m_eear = 0;
        m_rpc = 0; m_hpc = 0; m_rv = 0; m_hv = 0; m_bad = 0; m_can = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        compare_all("R1");

        // R13 plain status write, prefix low
        op("R13", 0, 0, 0, 0, 0, 1, 32'h0000_8001);
        // R2 syscall / fp, both delay-slot states
        op("R2", 1, 12, 32'h0000_1000, 0, 0, 0, 0);
        op("R2", 1, 13, 32'h0000_2000, 1, 0, 0, 0);
        // R3 at-fault classes
        op("R3", 1, 2, 32'h0000_3000, 0, 0, 0, 0);
        op("R3", 1, 6, 32'h0000_3100, 1, 0, 0, 0);
        op("R3", 1, 11, 32'h0000_3200, 1, 0, 0, 0);
        // R8 illegal loads eear
        op("R8", 1, 7, 32'h0000_4444, 0, 0, 0, 0);
        op("R8", 1, 7, 32'h0000_5550, 1, 0, 0, 0);
        // R4 reset code keeps epc
        op("R4", 1, 1, 32'h0ABC_0000, 0, 0, 0, 0);
        // R9 return
        op("R9", 0, 0, 0, 0, 1, 0, 0);
        // R6 prefix high
        op("R6", 0, 0, 0, 0, 0, 1, 32'h0000_4000);
        op("R6", 1, 12, 32'h0000_6000, 0, 0, 0, 0);
        op("R5", 1, 13, 32'h0000_6100, 1, 0, 0, 0);
        op("R9", 0, 0, 0, 0, 1, 0, 0);
        // R7 trap
        op("R7", 1, 14, 32'h0000_7770, 1, 0, 0, 0);
        // R11 unsupported codes
        op("R11", 1, 0, 32'h0000_8880, 0, 0, 0, 0);
        op("R11", 1, 3, 32'h0000_8884, 1, 1, 0, 0);
        op("R11", 1, 15, 32'h0000_8888, 0, 0, 1, 32'h1234_5678);
        // R12 entry beats return
        op("R12", 1, 6, 32'h0000_9000, 0, 1, 0, 0);
        // R13 write dropped during entry and return
        op("R13", 1, 11, 32'h0000_9100, 0, 0, 1, 32'hFFFF_FFFF);
        op("R13", 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
        // R10 cancel with prefix low again and a boundary PC
        op("R10", 0, 0, 0, 0, 0, 1, 32'h0000_0000);
        op("R10", 1, 11, 32'h0000_0000, 1, 0, 0, 0);
        op("R2", 1, 12, 32'hFFFF_FFFC, 0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule